// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the divider settings of a frequency synthesizer: a 9-bit loop modulus, a 2-bit output-divider select and a 3-bit test-mode code. It has two load paths that write the same registers. A parallel path takes the modulus and divider select from pins when its load strobe goes from low to high. A three-wire serial path has a data line, a shift clock and a load strobe. It shifts bits into a 14-bit register and copies that register into the settings when the load strobe goes from high to low.

All three serial wires and the parallel strobe come from the board. They are brought into the core clock domain through two-flop synchronizers, and their edges are detected there. Holding the parallel strobe low acts as a power-up hold. In that state serial loads are ignored, the test code is forced to zero, and the test output shows the top bit of the shift register. The test code selects the source of the test output, and one code value raises a bypass mode flag.

Top module: `synth_cfg_if`

## Requirements
- R1: After reset the modulus output is all ones (0x1FF), the divider select is 2'b11, the test code is 3'b000, and both the test output and the bypass flag are 0.
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of the 14-bit shift register, and all older bits move up one place. A falling edge of the serial load strobe copies bits [13:11] into the test code, bits [10:9] into the divider select and bits [8:0] into the modulus. The word is therefore sent as test code, then divider select, then modulus, each field MSB first.
- R3: A rising edge of the parallel load strobe captures the modulus pins and the divider-select pins. It leaves the test code unchanged.
- R4: When a parallel rising edge and a serial falling edge are detected in the same core cycle, the parallel values are the ones stored.
- R5: While the parallel load strobe is low, serial load edges have no effect on any setting. Shifting still takes place.
- R6: While the parallel load strobe is low, the test code is held at 3'b000 and the test output shows shift-register bit 13.
- R7: With the parallel strobe high, test code 3'b000 drives the test output to 0 and test code 3'b001 drives it to 1.
- R8: Test code 3'b110 sets the bypass flag, and the test output then follows the synchronized serial clock level. No other code sets the flag.
- R9: With the parallel strobe high, every other test code puts shift-register bit 13 on the test output.
- R10: Shifting serial bits without a load strobe edge leaves the modulus, the divider select and the test code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_load | input | 1 | Parallel load strobe, captures on rising edge, holds while low |
| par_m | input | 9 | Parallel loop modulus |
| par_n | input | 2 | Parallel output-divider select |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe, captures on falling edge |
| m_val | output | 9 | Stored loop modulus |
| n_sel | output | 2 | Stored output-divider select |
| t_code | output | 3 | Stored test code |
| bypass | output | 1 | High when the test code selects bypass |
| test_out | output | 1 | Test output |

## Verification
Serial words with random modulus, divider and test fields are loaded with the parallel strobe high. These runs separate a correct field order and bit order from a swapped or reversed one, and they show the test output under each code. Directed sequences then cover four more cases. A parallel load after a serial one shows which path the registers listen to. Coincident edges on both strobes separate parallel priority from serial priority. Serial loads with the parallel strobe held low separate the hold from a missing gate. Shifts without a strobe separate stored settings from settings that follow the shift register. The test-output checks under the bypass code and under the shift-out codes separate the three test-output sources.

// File: rtl/cfg_pkg.sv
// Package: widths, field positions and test codes shared by the
// configuration port modules.
package cfg_pkg;
    parameter int M_W = 9;
    parameter int N_W = 2;
    parameter int T_W = 3;
    localparam int SR_W  = T_W + N_W + M_W;
    localparam int N_LSB = M_W;
    localparam int T_LSB = M_W + N_W;

    localparam logic [T_W-1:0] T_DRV_LOW  = 3'b000;
    localparam logic [T_W-1:0] T_DRV_HIGH = 3'b001;
    localparam logic [T_W-1:0] T_BYPASS   = 3'b110;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
// Module: cfg_sync
// Multi-bit synchronizer chain. Each bit is independent, so the
// inputs are assumed to be quasi-static board signals.
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Move the value one stage further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else if (g == 0) stg[g] <= d;
                else stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
// Module: cfg_shift
// Serial input shift register. Assumes the shift pulse and the data
// bit are already in the core domain with matching latency.
module cfg_shift #(
    parameter int W = cfg_pkg::SR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    // Shift a new bit into the bottom on each shift pulse
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (shift) q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/cfg_regs.sv
// Module: cfg_regs
// Holds the settings. The parallel capture wins over the serial
// capture. A low parallel strobe blocks serial loads and clears
// the test code.
module cfg_regs
    import cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            par_rise,
    input  logic            par_low,
    input  logic            ser_fall,
    input  logic [M_W-1:0]  par_m,
    input  logic [N_W-1:0]  par_n,
    input  logic [SR_W-1:0] sreg,
    output logic [M_W-1:0]  m_val,
    output logic [N_W-1:0]  n_sel,
    output logic [T_W-1:0]  t_code
);
    cfg_word_t word;
    assign word = cfg_word_t'(sreg);

    // Update the settings from whichever load path is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_val  <= '1;
            n_sel  <= '1;
            t_code <= '0;
        end else begin
            if (par_rise) begin
                m_val <= par_m;
                n_sel <= par_n;
            end else if (ser_fall && !par_low) begin
                m_val  <= word.m;
                n_sel  <= word.n;
                t_code <= word.t;
            end
            if (par_low) t_code <= '0;
        end
    end
endmodule

// File: rtl/cfg_testsel.sv
// Module: cfg_testsel
// Registered test output source selection, driven by the hold
// state and the stored test code.
module cfg_testsel
    import cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_low,
    input  logic [T_W-1:0] t_code,
    input  logic           top_bit,
    input  logic           sclk_lvl,
    output logic           test_out
);
    logic nxt;

    // Pick the source for the test output
    always_comb begin
        if (par_low)                  nxt = top_bit;
        else if (t_code == T_DRV_LOW)  nxt = 1'b0;
        else if (t_code == T_DRV_HIGH) nxt = 1'b1;
        else if (t_code == T_BYPASS)   nxt = sclk_lvl;
        else                           nxt = top_bit;
    end

    // Register the selected value
    always_ff @(posedge clk) begin
        if (!rst_n) test_out <= 1'b0;
        else        test_out <= nxt;
    end
endmodule

// File: rtl/synth_cfg_if.sv
// Module: synth_cfg_if
// Top level of the divider configuration port. Brings the board
// strobes into the core domain, detects their edges, and connects
// the shift register, the setting registers and the test selector.
// Assumes the parallel pins are stable around the strobe edge and
// that each serial level lasts at least three core cycles.
module synth_cfg_if
    import cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] m_val,
    output logic [N_W-1:0] n_sel,
    output logic [T_W-1:0] t_code,
    output logic           bypass,
    output logic           test_out
);
    localparam int SYNC_W = 4;

    logic [SYNC_W-1:0] raw_in, syn;
    logic              sclk_s, sdat_s, sld_s, pld_s;
    logic              sclk_d, sld_d, pld_d;
    logic              shift_p, ser_fall, par_rise, par_low;
    logic [SR_W-1:0]   sreg;

    assign raw_in = {par_load, ser_load, ser_data, ser_clk};
    assign {pld_s, sld_s, sdat_s, sclk_s} = syn;

    cfg_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    // Keep the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) {sclk_d, sld_d, pld_d} <= '0;
        else        {sclk_d, sld_d, pld_d} <= {sclk_s, sld_s, pld_s};
    end

    assign shift_p  = sclk_s & ~sclk_d;
    assign ser_fall = ~sld_s & sld_d;
    assign par_rise = pld_s & ~pld_d;
    assign par_low  = ~pld_s;

    cfg_shift #(.W(SR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift(shift_p), .sin(sdat_s), .q(sreg)
    );

    cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .par_rise(par_rise), .par_low(par_low),
        .ser_fall(ser_fall), .par_m(par_m), .par_n(par_n), .sreg(sreg),
        .m_val(m_val), .n_sel(n_sel), .t_code(t_code)
    );

    assign bypass = (t_code == T_BYPASS);

    cfg_testsel u_test (
        .clk(clk), .rst_n(rst_n), .par_low(par_low), .t_code(t_code),
        .top_bit(sreg[SR_W-1]), .sclk_lvl(sclk_s), .test_out(test_out)
    );
endmodule

// File: rtl/synth_cfg_chk.sv
// Module: synth_cfg_chk
// Assertion checker bound into synth_cfg_if. It looks at the
// detected edges, the shift register and the stored settings.
module synth_cfg_chk
    import cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            par_rise,
    input  logic            par_low,
    input  logic            ser_fall,
    input  logic            shift_p,
    input  logic [M_W-1:0]  par_m,
    input  logic [SR_W-1:0] sreg,
    input  logic [M_W-1:0]  m_val,
    input  logic [N_W-1:0]  n_sel,
    input  logic [T_W-1:0]  t_code,
    input  logic            test_out
);
    p_par_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        par_rise |=> m_val == $past(par_m));
    p_ser_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_fall && !par_low && !par_rise) |=> m_val == $past(sreg[M_W-1:0]));
    p_ser_ign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_fall && par_low) |=> ($stable(m_val) && $stable(n_sel)));
    p_tclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_low |=> t_code == '0);
    p_tmon_r6: assert property (@(posedge clk) disable iff (!rst_n)
        par_low |=> test_out == $past(sreg[SR_W-1]));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_p && !ser_fall && !par_rise) |=> ($stable(m_val) && $stable(n_sel)));
endmodule

bind synth_cfg_if synth_cfg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .par_rise(par_rise), .par_low(par_low),
    .ser_fall(ser_fall), .shift_p(shift_p), .par_m(par_m), .sreg(sreg),
    .m_val(m_val), .n_sel(n_sel), .t_code(t_code), .test_out(test_out)
);

// File: tb/sim_synth_cfg_if.sv
// Bench for synth_cfg_if: directed corner cases and seeded random serial words.
module sim_synth_cfg_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_load = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_sel;
    logic [2:0] t_code;
    logic       bypass, test_out;
    int         n_run = 0, n_fail = 0;
    logic [13:0] sr_model = '0;

    always #4 clk = ~clk;

    synth_cfg_if u0 (.*);

    // Expected test output for a given code, shift top bit and clock level
    function automatic logic exp_test(input logic [2:0] t, input logic top, input logic sc);
        if (t == 3'b000) return 1'b0;
        if (t == 3'b001) return 1'b1;
        if (t == 3'b110) return sc;
        return top;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b;
        cyc(4);
        ser_clk = 1'b1;
        cyc(4);
        ser_clk = 1'b0;
        cyc(4);
        sr_model = {sr_model[12:0], b};
    endtask

    task automatic ser_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) ser_bit(w[i]);
    endtask

    task automatic ser_strobe;
        ser_load = 1'b1;
        cyc(4);
        ser_load = 1'b0;
        cyc(6);
    endtask

    task automatic par_capture(input logic [8:0] m, input logic [1:0] n);
        par_load = 1'b0;
        par_m = m;
        par_n = n;
        cyc(5);
        par_load = 1'b1;
        cyc(6);
    endtask

    initial begin
        #(8 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] rm;
        logic [1:0] rn;
        logic [2:0] rt;
        void'($urandom(32'h1429));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset values
        check("R1 m", m_val, 9'h1FF);
        check("R1 n", n_sel, 2'b11);
        check("R1 t", t_code, 0);
        check("R1 test", test_out, 0);
        check("R1 bypass", bypass, 0);

        // R6 top bit shown while held low; R5 serial load ignored
        ser_word({3'b110, 2'b01, 9'h0A5});
        check("R6 test shows top", test_out, 1);
        ser_strobe();
        check("R5 m unchanged", m_val, 9'h1FF);
        check("R5 n unchanged", n_sel, 2'b11);
        check("R6 t held zero", t_code, 0);

        // R3 parallel capture
        par_capture(9'h123, 2'b10);
        check("R3 m", m_val, 9'h123);
        check("R3 n", n_sel, 2'b10);
        check("R3 t unchanged", t_code, 0);
        check("R7 low code", test_out, 0);

        // R2 random serial words with the parallel strobe high
        for (int k = 0; k < 12; k++) begin
            rm = 9'($urandom);
            rn = 2'($urandom);
            rt = 3'($urandom);
            ser_word({rt, rn, rm});
            ser_strobe();
            check("R2 m", m_val, rm);
            check("R2 n", n_sel, rn);
            check("R2 t", t_code, rt);
            check("R8 flag", bypass, rt == 3'b110);
            check("R7/R8/R9 test", test_out, exp_test(rt, sr_model[13], 1'b0));
        end

        // R7 high code
        ser_word({3'b001, 2'b00, 9'h001});
        ser_strobe();
        check("R7 high code", test_out, 1);

        // R9 shift-out code follows the top bit
        ser_word({3'b011, 2'b01, 9'h0F0});
        ser_strobe();
        check("R9 top bit 0", test_out, 0);
        ser_bit(1'b1);
        check("R9 top bit 1", test_out, 1);
        // R10 shifting without a strobe left settings alone
        check("R10 m held", m_val, 9'h0F0);
        check("R10 n held", n_sel, 2'b01);
        check("R10 t held", t_code, 3'b011);

        // R8 bypass follows serial clock level
        ser_word({3'b110, 2'b11, 9'h055});
        ser_strobe();
        check("R8 flag set", bypass, 1);
        ser_clk = 1'b1;
        cyc(4);
        check("R8 follows clk high", test_out, 1);
        ser_clk = 1'b0;
        cyc(4);
        check("R8 follows clk low", test_out, 0);

        // R4 coincident edges: parallel wins
        par_load = 1'b0;
        par_m = 9'h0C3;
        par_n = 2'b01;
        cyc(5);
        check("R6 t cleared", t_code, 0);
        check("R8 flag cleared", bypass, 0);
        ser_word({3'b010, 2'b10, 9'h111});
        ser_load = 1'b1;
        cyc(4);
        par_load = 1'b1;
        ser_load = 1'b0;
        cyc(6);
        check("R4 m parallel", m_val, 9'h0C3);
        check("R4 n parallel", n_sel, 2'b01);
        check("R4 t", t_code, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule